// File: doc/BRIEF.md
# Indexed Register and Memory Window

This block lets a host reach a large address space through two small registers. The host first writes a 32-bit index register. It then reads or writes a 4-byte data window, and the block forwards each window access to one of two targets. If the top bit of the index is set, the access goes to video memory. If that bit is clear, it goes to the internal register file. Accesses to the window may be 1, 2 or 4 bytes wide. For register targets, the byte offset inside the window is added to the index.

The block checks every window access before it forwards it. A memory access whose bytes would run past the end of memory is refused. A register access whose index falls inside the block's own local space (the window and the index register) is also refused, because it would loop back into the window. A refused access completes at once: a read returns zero and a write is discarded. It also sets a sticky error bit that software clears by writing 1 to it. A forwarded access holds the host with a wait signal until the chosen target acknowledges. Only one access is outstanding at any time.

Top module: `idx_window`

## Requirements
- R1: Reading the index register (host word 0, host_addr 0x0) returns the last 32-bit value written to it.
- R2: With index bit 31 set, a window access (host_addr 0x4 to 0x7) issues one memory request at byte address index[30:0]. The byte offset in the window is ignored. Data is right-aligned and little-endian: the byte at the lowest address is in bits 7:0.
- R3: A memory request is issued only when index[30:0] + nbytes <= MEM_BYTES. Otherwise no request is made, a read returns 0 and the sticky error bit is set.
- R4: With index bit 31 clear and index >= 8, a window access issues one register request at (index + host_addr[1:0]) modulo 2^REG_AW.
- R5: With index bit 31 clear and index < 8, a window access is refused: no request is made, a read returns 0 and the error bit is set.
- R6: A forwarded access holds host_wait high from the cycle it is accepted until the target acknowledges. The host completes one cycle after the acknowledge, so waits = 2 + target latency. Only one target request is active at a time, and it is held until acknowledged.
- R7: The error bit (bit 0 of the status word at host_addr 0x8, also shown on win_err) is sticky. Writing 1 to bit 0 clears it; writing 0 has no effect.
- R8: host_size encodes the width: 0 is 1 byte, 1 is 2 bytes, 2 and 3 are 4 bytes. Forwarded write data and returned read data are zeroed above the lowest nbytes bytes.
- R9: Index and status accesses complete with no wait. Reads of host word 3 (0xC) return 0. Writes to it change nothing.
- R10: After reset the index is 0, the error bit is 0, and neither target request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host access present; held until the cycle with host_wait low |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Byte address in the block's local space |
| host_size | input | 2 | Access width code |
| host_wdata | input | 32 | Right-aligned write data |
| host_rdata | output | 32 | Read data, valid when host_wait is low |
| host_wait | output | 1 | Host must hold its access |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_size | output | 2 | Memory access width code |
| mem_wdata | output | 32 | Memory write data, masked to width |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, sampled with mem_ack |
| reg_req | output | 1 | Register-file request, held until reg_ack |
| reg_write | output | 1 | Register request is a write |
| reg_addr | output | REG_AW | Register byte address |
| reg_size | output | 2 | Register access width code |
| reg_wdata | output | 32 | Register write data, masked to width |
| reg_ack | input | 1 | Register-file acknowledge |
| reg_rdata | input | 32 | Register read data, sampled with reg_ack |
| win_err | output | 1 | Sticky error bit |

## Verification
Local accesses and refused window accesses are due in the cycle in which they are presented. The error bit changes at the next clock edge. A forwarded access sees its request rise one edge after acceptance and its completion one edge after the acknowledge. The bench's access task therefore counts wait cycles and requires exactly 2 plus the responder's latency. Read data is sampled only in the cycle where host_wait is low. A reference model in the bench tracks the index, the error bit and the target stores. It compares the error output and request exclusivity at every falling edge, and it checks each access's data, wait count and issued request against the values it predicts.

// File: rtl/idx_window_pkg.sv
package idx_window_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MEM  = 2'd1,
      ST_REG  = 2'd2,
      ST_DONE = 2'd3
   } win_state_e;

   localparam int unsigned WORD_INDEX  = 0;
   localparam int unsigned WORD_WINDOW = 1;
   localparam int unsigned WORD_STATUS = 2;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    size_bytes = 3'd1;
         2'd1:    size_bytes = 3'd2;
         default: size_bytes = 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/idx_window_decode.sv
module idx_window_decode
   import idx_window_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 1048576,
   parameter int unsigned MEM_AW    = 20,
   parameter int unsigned REG_AW    = 14,
   parameter int unsigned HOST_AW   = 4
) (
   input  logic [31:0]         index,
   input  logic [HOST_AW-1:0]  host_addr,
   input  logic [1:0]          host_size,
   output logic                sel_index,
   output logic                sel_window,
   output logic                sel_status,
   output logic                win_mem,
   output logic                win_reg,
   output logic                win_bad,
   output logic [2:0]          nbytes,
   output logic [MEM_AW-1:0]   mem_addr,
   output logic [REG_AW-1:0]   reg_addr
);
   localparam int unsigned WW = HOST_AW - 2;

   logic [WW-1:0] word;
   logic          mem_space;
   logic          fits;
   logic          above_local;

   assign word       = host_addr[HOST_AW-1:2];
   assign sel_index  = (word == WW'(WORD_INDEX));
   assign sel_window = (word == WW'(WORD_WINDOW));
   assign sel_status = (word == WW'(WORD_STATUS));
   assign nbytes     = size_bytes(host_size);

   // memory space: end of access must not pass the memory size
   assign mem_space   = index[31];
   assign fits        = ({2'b00, index[30:0]} + 33'(nbytes)) <= 33'(MEM_BYTES);
   // register space: indices 0..7 alias the local registers
   assign above_local = (index[30:3] != '0);

   assign win_mem = sel_window &  mem_space & fits;
   assign win_reg = sel_window & ~mem_space & above_local;
   assign win_bad = sel_window & ~win_mem & ~win_reg;

   assign mem_addr = index[MEM_AW-1:0];
   assign reg_addr = index[REG_AW-1:0] + REG_AW'(host_addr[1:0]);

endmodule

// File: rtl/idx_window_lane.sv
module idx_window_lane #(
   parameter int unsigned LANES = 4
) (
   input  logic [2:0]         nbytes,
   input  logic [8*LANES-1:0] din,
   output logic [8*LANES-1:0] dout
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dout[8*i +: 8] = (3'(i) < nbytes) ? din[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/idx_window_fsm.sv
module idx_window_fsm
   import idx_window_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_mem,
   input  logic start_reg,
   input  logic mem_ack,
   input  logic reg_ack,
   output logic idle,
   output logic mem_req,
   output logic reg_req,
   output logic done
);
   win_state_e st, st_n;

   always_comb begin
      st_n = st;
      case (st)
         ST_IDLE: begin
            if (start_mem)      st_n = ST_MEM;
            else if (start_reg) st_n = ST_REG;
         end
         ST_MEM:  if (mem_ack) st_n = ST_DONE;
         ST_REG:  if (reg_ack) st_n = ST_DONE;
         ST_DONE: st_n = ST_IDLE;
         default: st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_n;
   end

   assign idle    = (st == ST_IDLE);
   assign mem_req = (st == ST_MEM);
   assign reg_req = (st == ST_REG);
   assign done    = (st == ST_DONE);

   // R6: a request stays up until its target acknowledges
   a_r6_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req);
   a_r6_reg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      reg_req && !reg_ack |=> reg_req);
   // R6: completion only follows an acknowledge
   a_r6_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past((mem_req && mem_ack) || (reg_req && reg_ack)));

endmodule

// File: rtl/idx_window.sv
module idx_window
   import idx_window_pkg::*;
#(
   parameter int unsigned MEM_BYTES = 1048576,
   parameter int unsigned REG_AW    = 14,
   parameter int unsigned HOST_AW   = 4,
   localparam int unsigned MEM_AW   = $clog2(MEM_BYTES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_valid,
   input  logic               host_write,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [1:0]         host_size,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   output logic               host_wait,
   output logic               mem_req,
   output logic               mem_write,
   output logic [MEM_AW-1:0]  mem_addr,
   output logic [1:0]         mem_size,
   output logic [31:0]        mem_wdata,
   input  logic               mem_ack,
   input  logic [31:0]        mem_rdata,
   output logic               reg_req,
   output logic               reg_write,
   output logic [REG_AW-1:0]  reg_addr,
   output logic [1:0]         reg_size,
   output logic [31:0]        reg_wdata,
   input  logic               reg_ack,
   input  logic [31:0]        reg_rdata,
   output logic               win_err
);
   if (MEM_BYTES < 4) begin : g_bad_mem
      $error("idx_window: MEM_BYTES must be at least 4");
   end
   if (MEM_AW > 31) begin : g_bad_memaw
      $error("idx_window: memory must fit 31 address bits");
   end
   if (REG_AW < 4 || REG_AW > 31) begin : g_bad_regaw
      $error("idx_window: REG_AW out of range");
   end
   if (HOST_AW < 4) begin : g_bad_hostaw
      $error("idx_window: HOST_AW must cover four words");
   end

   logic [31:0]       index_q;
   logic              err_q;
   logic              sel_index, sel_window, sel_status;
   logic              win_mem, win_reg, win_bad;
   logic [2:0]        nbytes;
   logic [MEM_AW-1:0] dec_mem_addr;
   logic [REG_AW-1:0] dec_reg_addr;
   logic              idle, done, accept, clr_err;
   logic              q_write;
   logic [1:0]        q_size;
   logic [2:0]        q_nb;
   logic [MEM_AW-1:0] q_mem_addr;
   logic [REG_AW-1:0] q_reg_addr;
   logic [31:0]       q_wdata, wr_masked, rd_raw, rd_masked, rsp_q;

   idx_window_decode #(
      .MEM_BYTES(MEM_BYTES), .MEM_AW(MEM_AW), .REG_AW(REG_AW), .HOST_AW(HOST_AW)
   ) u_dec (
      .index(index_q), .host_addr(host_addr), .host_size(host_size),
      .sel_index(sel_index), .sel_window(sel_window), .sel_status(sel_status),
      .win_mem(win_mem), .win_reg(win_reg), .win_bad(win_bad),
      .nbytes(nbytes), .mem_addr(dec_mem_addr), .reg_addr(dec_reg_addr)
   );

   idx_window_lane #(.LANES(4)) u_wlane (
      .nbytes(nbytes), .din(host_wdata), .dout(wr_masked)
   );

   assign rd_raw = mem_req ? mem_rdata : reg_rdata;

   idx_window_lane #(.LANES(4)) u_rlane (
      .nbytes(q_nb), .din(rd_raw), .dout(rd_masked)
   );

   assign accept  = host_valid & idle;
   assign clr_err = accept & host_write & sel_status & host_wdata[0];

   idx_window_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .start_mem(accept & win_mem), .start_reg(accept & win_reg),
      .mem_ack(mem_ack), .reg_ack(reg_ack),
      .idle(idle), .mem_req(mem_req), .reg_req(reg_req), .done(done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         err_q   <= 1'b0;
      end else begin
         if (accept && host_write && sel_index) index_q <= host_wdata;
         if (accept && win_bad)                 err_q <= 1'b1;
         else if (clr_err)                      err_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_write    <= 1'b0;
         q_size     <= '0;
         q_nb       <= 3'd1;
         q_mem_addr <= '0;
         q_reg_addr <= '0;
         q_wdata    <= '0;
      end else if (accept && (win_mem || win_reg)) begin
         q_write    <= host_write;
         q_size     <= host_size;
         q_nb       <= nbytes;
         q_mem_addr <= dec_mem_addr;
         q_reg_addr <= dec_reg_addr;
         q_wdata    <= wr_masked;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_q <= '0;
      else if ((mem_req && mem_ack) || (reg_req && reg_ack))
         rsp_q <= q_write ? '0 : rd_masked;
   end

   always_comb begin
      host_rdata = '0;
      if (done) host_rdata = rsp_q;
      else if (idle) begin
         if (sel_index)       host_rdata = index_q;
         else if (sel_status) host_rdata = {31'b0, err_q};
      end
   end

   assign host_wait = mem_req | reg_req | (accept & (win_mem | win_reg));

   assign mem_write = q_write;
   assign mem_addr  = q_mem_addr;
   assign mem_size  = q_size;
   assign mem_wdata = q_wdata;
   assign reg_write = q_write;
   assign reg_addr  = q_reg_addr;
   assign reg_size  = q_size;
   assign reg_wdata = q_wdata;
   assign win_err   = err_q;

   // R3: every issued memory request lies inside memory
   a_r3_mem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (33'(mem_addr) + 33'(size_bytes(mem_size))) <= 33'(MEM_BYTES));
   // R5: a refused access raises the error bit on the next edge
   a_r5_refuse_flags: assert property (@(posedge clk) disable iff (!rst_n)
      accept && win_bad |=> win_err);
   // R7: the error bit only falls on a write of 1 to the status word
   a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      win_err && !clr_err |=> win_err);
   // R1: the index only changes on a host write to it
   a_r1_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(accept && host_write && sel_index) |=> $stable(index_q));
   // R6: the host is stalled while a target request is pending
   a_r6_wait_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || reg_req) |-> host_wait);

endmodule

// File: tb/idx_window_tb.sv
module idx_window_tb;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_BYTES  = 4096;
   localparam int REG_AW     = 12;
   localparam int MEM_AW     = $clog2(MEM_BYTES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_valid = 1'b0, host_write = 1'b0;
   logic [3:0] host_addr = '0;
   logic [1:0] host_size = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic host_wait;
   logic mem_req, mem_write, mem_ack = 1'b0;
   logic [MEM_AW-1:0] mem_addr;
   logic [1:0] mem_size;
   logic [31:0] mem_wdata, mem_rdata = '0;
   logic reg_req, reg_write, reg_ack = 1'b0;
   logic [REG_AW-1:0] reg_addr;
   logic [1:0] reg_size;
   logic [31:0] reg_wdata, reg_rdata = '0;
   logic win_err;

   always #(CLK_PERIOD/2) clk = ~clk;

   idx_window #(.MEM_BYTES(MEM_BYTES), .REG_AW(REG_AW), .HOST_AW(4)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
      .host_size(host_size), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_wait(host_wait),
      .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata),
      .reg_req(reg_req), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_size(reg_size), .reg_wdata(reg_wdata), .reg_ack(reg_ack),
      .reg_rdata(reg_rdata),
      .win_err(win_err)
   );

   int n_cmp = 0, n_bad = 0;
   bit ended = 0;
   bit mon_on = 0;

   // reference state
   logic [31:0] index_m = '0;
   logic        err_m = 1'b0;
   logic [7:0]  mem_m [int];
   logic [31:0] reg_m [int];
   int mem_lat = 0, reg_lat = 0, mcnt = 0, rcnt = 0;
   int mreqs = 0, rreqs = 0;
   logic [31:0] last_addr, last_wdata;
   logic [1:0]  last_size;
   logic        last_write;

   function automatic int nb_of(input logic [1:0] sz);
      return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
   endfunction

   function automatic logic [31:0] mask_of(input int nb);
      return (nb >= 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*nb)) - 32'h1);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // memory responder
   always @(negedge clk) begin
      if (mem_req && !mem_ack) begin
         if (mcnt >= mem_lat) begin
            int nb;
            logic [31:0] d;
            mcnt = 0;
            nb = nb_of(mem_size);
            mreqs++;
            last_addr = 32'(mem_addr); last_size = mem_size;
            last_write = mem_write; last_wdata = mem_wdata;
            d = 32'hEEEE_EEEE;
            for (int i = 0; i < nb; i++) begin
               if (mem_write) mem_m[int'(mem_addr) + i] = mem_wdata[8*i +: 8];
               else d[8*i +: 8] = mem_m.exists(int'(mem_addr) + i) ? mem_m[int'(mem_addr) + i] : 8'h00;
            end
            mem_rdata = d;
            mem_ack = 1'b1;
         end else mcnt++;
      end else mem_ack = 1'b0;
   end

   // register-file responder
   always @(negedge clk) begin
      if (reg_req && !reg_ack) begin
         if (rcnt >= reg_lat) begin
            rcnt = 0;
            rreqs++;
            last_addr = 32'(reg_addr); last_size = reg_size;
            last_write = reg_write; last_wdata = reg_wdata;
            if (reg_write) reg_m[int'(reg_addr)] = reg_wdata;
            reg_rdata = reg_m.exists(int'(reg_addr)) ? reg_m[int'(reg_addr)]
                                                     : (32'hC0DE_0000 | 32'(reg_addr));
            reg_ack = 1'b1;
         end else rcnt++;
      end else reg_ack = 1'b0;
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (mon_on) begin
         chk("R7 win_err vs model", {31'b0, win_err}, {31'b0, err_m});
         chk("R6 single request", {31'b0, mem_req & reg_req}, 32'h0);
      end
   end

   task automatic acc(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                      input logic [31:0] wd, output logic [31:0] rd, output int waits);
      @(negedge clk);
      host_valid = 1'b1; host_write = wr; host_addr = a; host_size = sz; host_wdata = wd;
      waits = 0;
      forever begin
         #1;
         if (!host_wait) break;
         waits++;
         if (waits > 1000) break;
         @(negedge clk);
      end
      rd = host_rdata;
      @(posedge clk);
      #1 host_valid = 1'b0;
   endtask

   // one host access with predicted result; kind 0 local, 1 mem, 2 reg, 3 refused
   task automatic op(input string tag, input logic wr, input logic [3:0] a,
                     input logic [1:0] sz, input logic [31:0] wd);
      int nb, kind, m0, r0, waits, ew;
      logic [31:0] rd, erd, taddr;
      nb = nb_of(sz);
      kind = 0; erd = '0; taddr = '0;
      if (a[3:2] == 2'd0) erd = index_m;
      else if (a[3:2] == 2'd2) erd = {31'b0, err_m};
      else if (a[3:2] == 2'd1) begin
         if (index_m[31]) begin
            if (longint'(index_m[30:0]) + nb <= MEM_BYTES) begin
               kind = 1; taddr = {1'b0, index_m[30:0]};
               for (int i = 0; i < nb; i++)
                  erd[8*i +: 8] = mem_m.exists(int'(taddr) + i) ? mem_m[int'(taddr) + i] : 8'h00;
            end else kind = 3;
         end else if (index_m[30:0] >= 8) begin
            kind = 2;
            taddr = (index_m + 32'(a[1:0])) & ((32'h1 << REG_AW) - 1);
            erd = (reg_m.exists(int'(taddr)) ? reg_m[int'(taddr)] : (32'hC0DE_0000 | taddr))
                  & mask_of(nb);
         end else kind = 3;
      end
      ew = (kind == 1) ? 2 + mem_lat : (kind == 2) ? 2 + reg_lat : 0;
      m0 = mreqs; r0 = rreqs;
      acc(wr, a, sz, wd, rd, waits);
      // model update after the completing edge
      if (a[3:2] == 2'd0 && wr) index_m = wd;
      if (kind == 3) err_m = 1'b1;
      else if (a[3:2] == 2'd2 && wr && wd[0]) err_m = 1'b0;
      chk({tag, " waits"}, 32'(waits), 32'(ew));
      if (!wr) chk({tag, " rdata"}, rd, erd);
      chk({tag, " mem requests"}, 32'(mreqs - m0), (kind == 1) ? 32'd1 : 32'd0);
      chk({tag, " reg requests"}, 32'(rreqs - r0), (kind == 2) ? 32'd1 : 32'd0);
      if (kind == 1 || kind == 2) begin
         chk({tag, " target addr"}, last_addr, taddr);
         chk({tag, " target size/dir"}, {29'b0, last_write, last_size}, {29'b0, wr, sz});
         if (wr) chk({tag, " target wdata"}, last_wdata, wd & mask_of(nb));
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!ended) begin
         ended = 1;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      chk("R10 err at reset", {31'b0, win_err}, 32'h0);
      chk("R10 no request at reset", {30'b0, mem_req, reg_req}, 32'h0);
      rst_n = 1'b1;
      mon_on = 1;
      op("R10 index reset value", 1'b0, 4'h0, 2'd2, '0);

      // R1 index readback
      op("R1 write index", 1'b1, 4'h0, 2'd2, 32'h1234_5678);
      op("R1 read index", 1'b0, 4'h0, 2'd2, '0);

      // R9 unused word and local timing
      op("R9 read word 3", 1'b0, 4'hC, 2'd2, '0);
      op("R9 write word 3", 1'b1, 4'hC, 2'd2, 32'hFFFF_FFFF);
      op("R9 index unchanged", 1'b0, 4'h0, 2'd2, '0);
      op("R9 status unchanged", 1'b0, 4'h8, 2'd2, '0);

      // R2 memory space, little-endian, offset ignored
      op("R2 set mem index", 1'b1, 4'h0, 2'd2, 32'h8000_0100);
      op("R2 mem write word", 1'b1, 4'h4, 2'd2, 32'hA1B2_C3D4);
      op("R2 mem read word", 1'b0, 4'h4, 2'd2, '0);
      op("R2 offset ignored", 1'b0, 4'h6, 2'd0, '0);
      op("R2 set byte index", 1'b1, 4'h0, 2'd2, 32'h8000_0101);
      op("R2 mem read byte", 1'b0, 4'h4, 2'd0, '0);

      // R8 widths and masking
      op("R8 set index", 1'b1, 4'h0, 2'd2, 32'h8000_0200);
      op("R8 half write masked", 1'b1, 4'h5, 2'd1, 32'hFFFF_5A6B);
      op("R8 half read", 1'b0, 4'h4, 2'd1, '0);
      op("R8 code 3 is word", 1'b0, 4'h4, 2'd3, '0);
      op("R8 byte write masked", 1'b1, 4'h4, 2'd0, 32'h1234_5677);
      op("R8 byte read", 1'b0, 4'h4, 2'd0, '0);

      // R6 target latency
      mem_lat = 3;
      op("R6 slow mem read", 1'b0, 4'h4, 2'd2, '0);
      mem_lat = 0;

      // R3 bounds
      op("R3 idx last word", 1'b1, 4'h0, 2'd2, 32'h8000_0000 | (MEM_BYTES - 4));
      op("R3 last word ok", 1'b1, 4'h4, 2'd2, 32'hCAFE_F00D);
      op("R3 idx end-3", 1'b1, 4'h0, 2'd2, 32'h8000_0000 | (MEM_BYTES - 3));
      op("R3 word past end", 1'b0, 4'h4, 2'd2, '0);
      op("R3 byte at end-3", 1'b0, 4'h4, 2'd0, '0);
      op("R7 status read set", 1'b0, 4'h8, 2'd2, '0);
      op("R7 write 0 keeps", 1'b1, 4'h8, 2'd2, 32'hFFFF_FFFE);
      op("R7 still set", 1'b0, 4'h8, 2'd2, '0);
      op("R7 write 1 clears", 1'b1, 4'h8, 2'd2, 32'h0000_0001);
      op("R7 cleared", 1'b0, 4'h8, 2'd2, '0);
      op("R3 idx end-1", 1'b1, 4'h0, 2'd2, 32'h8000_0000 | (MEM_BYTES - 1));
      op("R3 half past end write", 1'b1, 4'h4, 2'd1, 32'h0000_BEEF);
      op("R3 byte at last", 1'b0, 4'h4, 2'd0, '0);
      op("R3 idx far", 1'b1, 4'h0, 2'd2, 32'hFFFF_FFFF);
      op("R3 far byte refused", 1'b0, 4'h4, 2'd0, '0);
      op("R7 clear again", 1'b1, 4'h8, 2'd2, 32'h1);

      // R4 register space with offset
      reg_lat = 2;
      op("R4 set reg index", 1'b1, 4'h0, 2'd2, 32'h0000_0040);
      op("R4 byte write off3", 1'b1, 4'h7, 2'd0, 32'hABCD_EF99);
      op("R4 byte read off3", 1'b0, 4'h7, 2'd0, '0);
      op("R4 half read off2", 1'b0, 4'h6, 2'd1, '0);
      op("R4 set wrap index", 1'b1, 4'h0, 2'd2, 32'h0000_1FFE);
      op("R4 address wraps", 1'b0, 4'h7, 2'd2, '0);
      reg_lat = 0;

      // R5 loop-back refusal
      op("R5 set index 7", 1'b1, 4'h0, 2'd2, 32'h0000_0007);
      op("R5 index 7 refused", 1'b0, 4'h4, 2'd2, '0);
      op("R5 write refused", 1'b1, 4'h5, 2'd0, 32'h55);
      op("R7 clear", 1'b1, 4'h8, 2'd2, 32'h1);
      op("R5 set index 0", 1'b1, 4'h0, 2'd2, 32'h0);
      op("R5 index 0 refused", 1'b0, 4'h4, 2'd2, '0);
      op("R5 set index 8", 1'b1, 4'h0, 2'd2, 32'h8);
      op("R5 index 8 allowed", 1'b0, 4'h4, 2'd2, '0);

      repeat (3) @(posedge clk);
      if (!ended) begin
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule